// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block drives the reset line of a processor from two sources. The first is a supply-good indication: a synchronous digital input from an external comparator. The second is a watchdog that the processor must keep alive by pulling a shared chip-select/kick pin low at regular intervals. Any reset is stretched, so the processor leaves reset only after a fixed hold interval during which nothing has gone wrong.

The watchdog interval comes from a 2-bit selection held in a status register. Three of its codes pick a timeout and the fourth turns the watchdog off. The kick pin is synchronised and filtered, so a glitch shorter than the minimum low width does not count as a kick. Every time the watchdog expires, a one-cycle pulse is raised, and a flag register can use it to tell a watchdog reset from a supply reset. All delays are parameters counted in clock ticks, so the same RTL serves silicon timing and short simulations.

Top module: `sup_rst_ctrl`

## Requirements
- R1: When `supply_ok_i` is sampled low at a clock edge, reset is asserted after that edge. It stays asserted for as long as `supply_ok_i` remains low.
- R2: Reset is released at the edge that completes `HOLD_TICKS` consecutive edges with `supply_ok_i` high and `por_i` low. A single low sample during that run restarts the count from zero.
- R3: While `por_i` is high, reset is asserted. After `por_i` falls, reset is released exactly as in R2.
- R4: `wd_sel_i` chooses the watchdog timeout: 2'b00 gives `TO_LONG_TICKS`, 2'b01 gives `TO_MID_TICKS`, 2'b10 gives `TO_SHORT_TICKS`, and 2'b11 disables the watchdog (no expiry, no reset). If no kick arrives, expiry is flagged at the edge `T` edges after reset release, where `T` is the selected timeout.
- R5: Only a high-to-low transition of `cs_kick_i` restarts the watchdog. If the pin is held high or held low without further falls, the watchdog expires.
- R6: `cs_kick_i` passes through a two-flop synchroniser. A fall counts as a kick only if the pin is then sampled low on `KICK_MIN_TICKS` consecutive edges; a shorter low pulse is ignored. If the first low sample is at edge D and the pulse is long enough, the watchdog expires at edge D + `KICK_MIN_TICKS` + T + 2.
- R7: A watchdog expiry asserts reset for exactly `HOLD_TICKS` cycles. The watchdog does not count while reset is active, and it restarts from zero when reset is released.
- R8: `wdt_fired_o` is a single-cycle pulse, raised one cycle before the reset it causes. It is never raised for a supply or power-on reset.
- R9: `RST_ACTIVE_LOW` = 1 drives `rst_o` low while reset is active. `RST_ACTIVE_LOW` = 0 drives it high while reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all delays count its rising edges |
| por_i | input | 1 | Raw power-on reset, synchronous, active high |
| supply_ok_i | input | 1 | Supply-good indication from the comparator, synchronous |
| cs_kick_i | input | 1 | Shared chip-select/watchdog kick pin, asynchronous |
| wd_sel_i | input | 2 | Watchdog timeout selection from the status register |
| rst_o | output | 1 | Processor reset, polarity set by `RST_ACTIVE_LOW` |
| wdt_fired_o | output | 1 | One-cycle pulse on each watchdog expiry |

## Verification
The bench tries each of the three timeout codes with the kick pin held high and then held low, cycling through two expiries per code. This separates the code-to-timeout mapping from the pin-level behaviour, and shows that the counter restarts from zero after each watchdog reset. A kick low for exactly the minimum width sets a precise expiry edge. A kick one sample shorter must leave the original expiry edge in place, which distinguishes the width filter from plain edge detection. A periodic kick train and the disabled code must never fire. Supply drops, including a dip in the middle of the hold interval, check that the hold count restarts and that no watchdog pulse appears. A second, active-high instance is compared against the first on every cycle.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        WD_SEL_LONG  = 2'b00,
        WD_SEL_MID   = 2'b01,
        WD_SEL_SHORT = 2'b10,
        WD_SEL_OFF   = 2'b11
    } wd_sel_e;

    // Reasons that force the reset hold counter back to zero.
    typedef struct packed {
        logic power_on;
        logic supply_bad;
        logic wdt_trip;
    } rst_req_t;

    // Width of a counter that must hold values 0..n.
    function automatic int unsigned cnt_w(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Timeout in ticks for a selection code; 0 when disabled.
    function automatic int unsigned pick_limit(wd_sel_e sel, int unsigned t_long,
                                               int unsigned t_mid, int unsigned t_short);
        case (sel)
            WD_SEL_LONG:  return t_long;
            WD_SEL_MID:   return t_mid;
            WD_SEL_SHORT: return t_short;
            default:      return 0;
        endcase
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sup_kick_qual.sv
module sup_kick_qual
    import sup_pkg::*;
#(
    parameter int unsigned KICK_MIN_TICKS = 1,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic kick_o
);
    localparam int unsigned KW = cnt_w(KICK_MIN_TICKS);
    localparam logic [KW-1:0] K_SAT  = KW'(KICK_MIN_TICKS);
    localparam logic [KW-1:0] K_LAST = KW'(KICK_MIN_TICKS - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [KW-1:0]          low_run_q;
    logic                   pin_s;

    assign pin_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
        end
    end

    // low_run_q counts low samples; it rests saturated so that a pin
    // already low after reset needs a fresh fall before it can kick.
    always_ff @(posedge clk) begin
        if (rst) begin
            low_run_q <= K_SAT;
            kick_o    <= 1'b0;
        end else begin
            kick_o <= !pin_s && (low_run_q == K_LAST);
            if (pin_s) begin
                low_run_q <= '0;
            end else if (low_run_q < K_SAT) begin
                low_run_q <= low_run_q + KW'(1);
            end
        end
    end

endmodule

// File: rtl/sup_wdt_core.sv
module sup_wdt_core
    import sup_pkg::*;
#(
    parameter int unsigned TO_LONG_TICKS  = 1400000,
    parameter int unsigned TO_MID_TICKS   = 600000,
    parameter int unsigned TO_SHORT_TICKS = 200000
) (
    input  logic    clk,
    input  logic    rst,
    input  wd_sel_e sel_i,
    input  logic    hold_i,
    input  logic    kick_i,
    output logic    fired_o
);
    localparam int unsigned TO_MAX = max3(TO_LONG_TICKS, TO_MID_TICKS, TO_SHORT_TICKS);
    localparam int unsigned CW     = cnt_w(TO_MAX);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_val;
    logic          enabled;

    always_comb begin
        enabled  = (sel_i != WD_SEL_OFF);
        last_val = CW'(pick_limit(sel_i, TO_LONG_TICKS, TO_MID_TICKS, TO_SHORT_TICKS) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            fired_o <= 1'b0;
        end else begin
            fired_o <= 1'b0;
            if (hold_i || !enabled || kick_i) begin
                cnt_q <= '0;
            end else if (cnt_q >= last_val) begin
                cnt_q   <= '0;
                fired_o <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

endmodule

// File: rtl/sup_rst_hold.sv
module sup_rst_hold
    import sup_pkg::*;
#(
    parameter int unsigned HOLD_TICKS = 200000
) (
    input  logic clk,
    input  logic por_i,
    input  logic supply_ok_i,
    input  logic wdt_trip_i,
    output logic active_o
);
    localparam int unsigned HW = cnt_w(HOLD_TICKS);
    localparam logic [HW-1:0] H_LAST = HW'(HOLD_TICKS - 1);

    rst_req_t      req;
    logic [HW-1:0] good_q;

    always_comb begin
        req.power_on   = por_i;
        req.supply_bad = !supply_ok_i;
        req.wdt_trip   = wdt_trip_i;
    end

    always_ff @(posedge clk) begin
        if (req.power_on || req.supply_bad || req.wdt_trip) begin
            active_o <= 1'b1;
            good_q   <= '0;
        end else if (active_o) begin
            if (good_q == H_LAST) begin
                active_o <= 1'b0;
                good_q   <= '0;
            end else begin
                good_q <= good_q + HW'(1);
            end
        end
    end

endmodule

// File: rtl/sup_rst_ctrl.sv
module sup_rst_ctrl
    import sup_pkg::*;
#(
    parameter int unsigned HOLD_TICKS     = 200000,
    parameter int unsigned TO_LONG_TICKS  = 1400000,
    parameter int unsigned TO_MID_TICKS   = 600000,
    parameter int unsigned TO_SHORT_TICKS = 200000,
    parameter int unsigned KICK_MIN_TICKS = 1,
    parameter bit          RST_ACTIVE_LOW = 1'b1
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic       supply_ok_i,
    input  logic       cs_kick_i,
    input  logic [1:0] wd_sel_i,
    output logic       rst_o,
    output logic       wdt_fired_o
);
    logic rst_active;
    logic kick;
    logic fired;

    sup_kick_qual #(
        .KICK_MIN_TICKS (KICK_MIN_TICKS),
        .SYNC_STAGES    (2)
    ) u_kick (
        .clk    (clk),
        .rst    (por_i),
        .pin_i  (cs_kick_i),
        .kick_o (kick)
    );

    sup_wdt_core #(
        .TO_LONG_TICKS  (TO_LONG_TICKS),
        .TO_MID_TICKS   (TO_MID_TICKS),
        .TO_SHORT_TICKS (TO_SHORT_TICKS)
    ) u_wdt (
        .clk     (clk),
        .rst     (por_i),
        .sel_i   (wd_sel_e'(wd_sel_i)),
        .hold_i  (rst_active),
        .kick_i  (kick),
        .fired_o (fired)
    );

    sup_rst_hold #(
        .HOLD_TICKS (HOLD_TICKS)
    ) u_hold (
        .clk         (clk),
        .por_i       (por_i),
        .supply_ok_i (supply_ok_i),
        .wdt_trip_i  (fired),
        .active_o    (rst_active)
    );

    assign wdt_fired_o = fired;

    generate
        if (RST_ACTIVE_LOW) begin : g_rst_low
            assign rst_o = ~rst_active;
        end else begin : g_rst_high
            assign rst_o = rst_active;
        end
    endgenerate

endmodule

// File: rtl/sup_rst_ctrl_chk.sv
module sup_rst_ctrl_chk #(
    parameter bit RST_ACTIVE_LOW = 1'b1
) (
    input logic       clk,
    input logic       por_i,
    input logic       supply_ok_i,
    input logic [1:0] wd_sel_i,
    input logic       rst_o,
    input logic       wdt_fired_o
);
    logic rst_on;
    assign rst_on = RST_ACTIVE_LOW ? ~rst_o : rst_o;

    // R1
    p_supply_low_rst_r1: assert property (@(posedge clk) disable iff (por_i)
        !supply_ok_i |=> rst_on);

    // R2
    p_release_good_r2: assert property (@(posedge clk) disable iff (por_i)
        $fell(rst_on) |-> ($past(supply_ok_i) && !$past(por_i)));

    // R4
    p_off_no_fire_r4: assert property (@(posedge clk) disable iff (por_i)
        wdt_fired_o |-> ($past(wd_sel_i) != 2'b11));

    // R7
    p_frozen_in_rst_r7: assert property (@(posedge clk) disable iff (por_i)
        wdt_fired_o |-> !$past(rst_on));

    // R8
    p_fire_then_rst_r8: assert property (@(posedge clk) disable iff (por_i)
        wdt_fired_o |=> rst_on);

    // R8
    p_fire_single_r8: assert property (@(posedge clk) disable iff (por_i)
        wdt_fired_o |=> !wdt_fired_o);

endmodule

bind sup_rst_ctrl sup_rst_ctrl_chk #(
    .RST_ACTIVE_LOW (RST_ACTIVE_LOW)
) u_chk (
    .clk         (clk),
    .por_i       (por_i),
    .supply_ok_i (supply_ok_i),
    .wd_sel_i    (wd_sel_i),
    .rst_o       (rst_o),
    .wdt_fired_o (wdt_fired_o)
);

// File: tb/sim_sup_rst_ctrl.sv
module sim_sup_rst_ctrl;
    localparam int HOLD = 8;
    localparam int TL   = 40;
    localparam int TM   = 24;
    localparam int TS   = 12;
    localparam int KMIN = 3;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       sup = 1'b0;
    logic       cs  = 1'b1;
    logic [1:0] sel = 2'b10;
    logic       rst0, rst1, f0, f1;
    int         vec = 0;
    int         bad = 0;

    always #5 clk = ~clk;

    sup_rst_ctrl #(
        .HOLD_TICKS(HOLD), .TO_LONG_TICKS(TL), .TO_MID_TICKS(TM),
        .TO_SHORT_TICKS(TS), .KICK_MIN_TICKS(KMIN), .RST_ACTIVE_LOW(1'b1)
    ) u0 (
        .clk(clk), .por_i(por), .supply_ok_i(sup), .cs_kick_i(cs),
        .wd_sel_i(sel), .rst_o(rst0), .wdt_fired_o(f0)
    );

    sup_rst_ctrl #(
        .HOLD_TICKS(HOLD), .TO_LONG_TICKS(TL), .TO_MID_TICKS(TM),
        .TO_SHORT_TICKS(TS), .KICK_MIN_TICKS(KMIN), .RST_ACTIVE_LOW(1'b0)
    ) u1 (
        .clk(clk), .por_i(por), .supply_ok_i(sup), .cs_kick_i(cs),
        .wd_sel_i(sel), .rst_o(rst1), .wdt_fired_o(f1)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // One clock edge, then sample at the falling edge; R9 compared every cycle.
    task automatic step();
        logic inv;
        @(negedge clk);
        inv = ~rst0;
        chk("R9 polarity", rst1, inv);
        chk("R8 fired match", f1, f0);
    endtask

    // Expects expiry at edge fire_at, reset for HOLD cycles, release after.
    task automatic run_pattern(input string req, input int fire_at,
                               input int lo_at, input int hi_at);
        for (int k = 1; k <= fire_at + 1 + HOLD; k++) begin
            step();
            chk(req, f0, k == fire_at);
            chk(req, ~rst0, (k >= fire_at + 1) && (k <= fire_at + HOLD));
            if (k == lo_at) cs = 1'b0;
            if (k == hi_at) cs = 1'b1;
        end
    endtask

    initial begin
        // R3: power-on state
        repeat (3) step();
        chk("R3 reset at por", ~rst0, 1'b1);
        chk("R8 no fire at por", f0, 1'b0);
        por = 1'b0;
        sup = 1'b1;
        for (int k = 1; k <= HOLD; k++) begin
            step();
            chk("R3 R2 hold after por", ~rst0, k < HOLD);
        end

        // R4 R7 R8: timeouts with pin held high, two expiries each
        run_pattern("R4 R5 R7 short", TS, -1, -1);
        run_pattern("R4 R5 R7 short", TS, -1, -1);
        sel = 2'b01;
        run_pattern("R4 R7 mid", TM, -1, -1);
        run_pattern("R4 R7 mid", TM, -1, -1);
        sel = 2'b00;
        // pin falls during reset: no effect on timing
        run_pattern("R4 R7 long", TL, TL + 2, -1);
        run_pattern("R5 R7 long pin low", TL, -1, -1);

        // R4: disabled code
        sel = 2'b11;
        cs  = 1'b1;
        for (int k = 1; k <= 150; k++) begin
            step();
            chk("R4 off no fire", f0, 1'b0);
            chk("R4 off no reset", ~rst0, 1'b0);
        end

        // R6: glitch of KMIN-1 samples ignored
        sel = 2'b10;
        run_pattern("R6 short glitch ignored", TS, 3, 3 + KMIN - 1);
        // R6: low for exactly KMIN samples restarts, exact latency
        run_pattern("R6 R5 minimum kick", 5 + 1 + KMIN + TS + 2, 5, 5 + KMIN);

        // R5: periodic kicks keep the processor running
        for (int k = 1; k <= 120; k++) begin
            step();
            chk("R5 kept alive no fire", f0, 1'b0);
            chk("R5 kept alive no reset", ~rst0, 1'b0);
            if (k % 8 == 2) cs = 1'b0;
            if (k % 8 == 6) cs = 1'b1;
        end

        // R1 R2 R8: supply drop, dip during hold
        sel = 2'b11;
        sup = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            step();
            chk("R1 supply low reset", ~rst0, 1'b1);
            chk("R8 no fire on supply", f0, 1'b0);
        end
        sup = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            step();
            chk("R2 holding", ~rst0, 1'b1);
        end
        sup = 1'b0;
        step();
        chk("R1 dip reset", ~rst0, 1'b1);
        sup = 1'b1;
        for (int k = 1; k <= HOLD; k++) begin
            step();
            chk("R2 hold restarted", ~rst0, k < HOLD);
            chk("R8 no fire on supply", f0, 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule